// File: doc/BRIEF.md
# Three-Segment Multiply-Add Pipeline

This block computes `A*B + C` on unsigned integers for a stream of operand sets, accepting one set per clock. The work is divided into three segments, each ending in registers. The first segment captures A and B. The second segment forms their product and, in the same clock, loads C. The third segment adds the product to C. Because C is loaded by the second segment, each operand set is spread over two consecutive enabled clocks: first A and B, then its C on the clock that follows.

The operand stream is qualified by a valid bit, and a valid bit travels with each set through the segments. A set that arrives with `in_valid` low becomes a bubble that never shows up as a result. The only way to apply back-pressure is the global `en` input. While `en` is low, every segment register, valid bits included, keeps its value, and the inputs are not sampled. A producer that has to pause lowers `en` and then presents the next A/B or C on the next clock that has `en` high. No ready signal exists.

Results are `2*WIDTH+1` bits wide, so no sum can be truncated. A synchronous reset clears the valid bits and leaves the datapath registers as they are.

Top module: `madd3_pipe`

## Requirements
- R1: A clock edge with `rst` high clears every valid bit, so `out_valid` is low after that edge and stays low until two enabled edges have captured a valid set.
- R2: An edge with `en` high and `in_valid` high captures `in_a` and `in_b` into the first segment.
- R3: When a result is valid, `out_result` equals A*B + C. A and B are the values captured at enabled edge k. C is the value on `in_c` at the next enabled edge, k+1.
- R4: A set captured at enabled edge k produces its result right after enabled edge k+2. With seven back-to-back sets following a reset, the first result appears after clock 3 and the last after clock 9.
- R5: `out_valid` is high after enabled edge k+2 exactly when `in_valid` was high at enabled edge k. Bubbles produce no result.
- R6: An edge with `en` low and `rst` low changes no register. `out_valid` and `out_result` hold, and `in_a`, `in_b`, `in_c` and `in_valid` are ignored at that edge.
- R7: The result is exact for all operand values, all-ones included. The most significant of its `2*WIDTH+1` bits is never set by a valid result.
- R8: With `en` held high, a new set is accepted on every clock and one result leaves on every clock, with three sets in flight at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears valid bits |
| en | input | 1 | Global advance enable; low freezes every segment |
| in_valid | input | 1 | Marks `in_a`/`in_b` as a real operand set |
| in_a | input | WIDTH | Multiplicand for the set entering segment 1 |
| in_b | input | WIDTH | Multiplier for the set entering segment 1 |
| in_c | input | WIDTH | Addend for the set that entered segment 1 one enabled clock earlier |
| out_valid | output | 1 | Segment 3 holds a real result |
| out_result | output | 2*WIDTH+1 | A*B + C |

## Verification
The bench pairs each C with its A/B by counting enabled edges, not wall clocks. A design that sampled C in the same clock as A/B, or that let C advance during a stall, produces wrong sums as soon as `en` toggles. Bubbles mixed into the stream catch valid bits that are dropped or duplicated, and a reset asserted with sets in flight catches a valid bit that was not cleared. All-ones operands catch a product or sum register that is too narrow. A fixed run of seven sets checks that the last result appears after clock 9 and not one clock early or late.

// File: rtl/madd3_pkg.sv
package madd3_pkg;
  localparam int unsigned MADD3_DEF_WIDTH = 8;

  function automatic int unsigned prod_bits(input int unsigned w);
    return 2 * w;
  endfunction

  function automatic int unsigned sum_bits(input int unsigned w);
    return 2 * w + 1;
  endfunction
endpackage

// File: rtl/madd3_seg_load.sv
module madd3_seg_load #(
  parameter int unsigned WIDTH = madd3_pkg::MADD3_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             q_valid,
  output logic [WIDTH-1:0] q_a,
  output logic [WIDTH-1:0] q_b
);
  // Segment 1: operand capture.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
    end else if (en) begin
      q_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      q_a <= in_a;
      q_b <= in_b;
    end
  end
endmodule

// File: rtl/madd3_seg_mul.sv
module madd3_seg_mul #(
  parameter int unsigned WIDTH = madd3_pkg::MADD3_DEF_WIDTH,
  localparam int unsigned PW   = madd3_pkg::prod_bits(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             d_valid,
  input  logic [WIDTH-1:0] d_a,
  input  logic [WIDTH-1:0] d_b,
  input  logic [WIDTH-1:0] in_c,
  output logic             q_valid,
  output logic [PW-1:0]    q_prod,
  output logic [WIDTH-1:0] q_c
);
  // Segment 2: the product and the late addend are loaded in the same clock.
  logic [PW-1:0] prod_w;

  always_comb begin
    prod_w = PW'(d_a) * PW'(d_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
    end else if (en) begin
      q_valid <= d_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      q_prod <= prod_w;
      q_c    <= in_c;
    end
  end
endmodule

// File: rtl/madd3_seg_add.sv
module madd3_seg_add #(
  parameter int unsigned WIDTH = madd3_pkg::MADD3_DEF_WIDTH,
  localparam int unsigned PW   = madd3_pkg::prod_bits(WIDTH),
  localparam int unsigned SW   = madd3_pkg::sum_bits(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             d_valid,
  input  logic [PW-1:0]    d_prod,
  input  logic [WIDTH-1:0] d_c,
  output logic             q_valid,
  output logic [SW-1:0]    q_sum
);
  // Segment 3: the sum is one bit wider than the product.
  logic [SW-1:0] sum_w;

  always_comb begin
    sum_w = SW'(d_prod) + SW'(d_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
    end else if (en) begin
      q_valid <= d_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      q_sum <= sum_w;
    end
  end
endmodule

// File: rtl/madd3_pipe.sv
module madd3_pipe #(
  parameter int unsigned WIDTH = madd3_pkg::MADD3_DEF_WIDTH,
  localparam int unsigned PW   = madd3_pkg::prod_bits(WIDTH),
  localparam int unsigned SW   = madd3_pkg::sum_bits(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [WIDTH-1:0] in_c,
  output logic             out_valid,
  output logic [SW-1:0]    out_result
);
  logic             s1_valid;
  logic [WIDTH-1:0] s1_a;
  logic [WIDTH-1:0] s1_b;
  logic             s2_valid;
  logic [PW-1:0]    s2_prod;
  logic [WIDTH-1:0] s2_c;

  madd3_seg_load #(.WIDTH(WIDTH)) u_seg1 (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .in_valid (in_valid),
    .in_a     (in_a),
    .in_b     (in_b),
    .q_valid  (s1_valid),
    .q_a      (s1_a),
    .q_b      (s1_b)
  );

  madd3_seg_mul #(.WIDTH(WIDTH)) u_seg2 (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .d_valid (s1_valid),
    .d_a     (s1_a),
    .d_b     (s1_b),
    .in_c    (in_c),
    .q_valid (s2_valid),
    .q_prod  (s2_prod),
    .q_c     (s2_c)
  );

  madd3_seg_add #(.WIDTH(WIDTH)) u_seg3 (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .d_valid (s2_valid),
    .d_prod  (s2_prod),
    .d_c     (s2_c),
    .q_valid (out_valid),
    .q_sum   (out_result)
  );
endmodule

// File: rtl/madd3_pipe_chk.sv
module madd3_pipe_chk #(
  parameter int unsigned WIDTH = madd3_pkg::MADD3_DEF_WIDTH,
  localparam int unsigned SW   = madd3_pkg::sum_bits(WIDTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             in_valid,
  input logic [WIDTH-1:0] in_a,
  input logic             s1_valid,
  input logic [WIDTH-1:0] s1_a,
  input logic             out_valid,
  input logic [SW-1:0]    out_result
);
  // Independent valid shadow that advances on enabled edges.
  logic [1:0] vshadow;
  logic       seen_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      vshadow  <= 2'b00;
      seen_rst <= 1'b1;
    end else if (en) begin
      vshadow  <= {vshadow[0], in_valid};
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (en && in_valid) |=> (s1_valid && s1_a == $past(in_a)));

  p_valid_track_r5: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && en) |=> (out_valid == $past(vshadow[1])));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && !en) |=> ($stable(out_valid) && $stable(out_result)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_result[SW-1]);
endmodule

bind madd3_pipe madd3_pipe_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .in_valid   (in_valid),
  .in_a       (in_a),
  .s1_valid   (s1_valid),
  .s1_a       (s1_a),
  .out_valid  (out_valid),
  .out_result (out_result)
);

// File: tb/madd3_pipe_bench.sv
`timescale 1ns/1ps
module madd3_pipe_bench;
  localparam int W  = 8;
  localparam int SW = 2 * W + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_a = '0;
  logic [W-1:0]  in_b = '0;
  logic [W-1:0]  in_c = '0;
  logic          out_valid;
  logic [SW-1:0] out_result;

  always #4 clk = ~clk;

  madd3_pipe #(.WIDTH(W)) u_madd3_pipe (
    .clk(clk), .rst(rst), .en(en), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_result(out_result)
  );

  // Behavioural model: input history indexed by enabled-edge count since reset.
  bit      hv [int];
  longint  ha [int];
  longint  hb [int];
  longint  hc [int];
  int      ne = 0;
  int      clk_no = 0;
  int      n_checks = 0;
  int      n_fail = 0;
  bit      done = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (clock %0d)", tag, act, exp, clk_no);
    end
  endtask

  task automatic compare();
    bit     ev;
    longint er;
    ev = (ne >= 3) ? hv[ne-3] : 1'b0;
    chk("R5 valid", longint'(out_valid), longint'(ev));
    if (ev) begin
      er = ha[ne-3] * hb[ne-3] + hc[ne-2];
      chk("R3 result", longint'(out_result), er);
    end
  endtask

  task automatic cyc(input bit e, input bit v, input int a, input int b, input int c);
    en = e; in_valid = v; in_a = W'(a); in_b = W'(b); in_c = W'(c);
    @(posedge clk);
    clk_no++;
    if (rst) begin
      ne = 0;
    end else if (e) begin
      hv[ne] = v; ha[ne] = a; hb[ne] = b; hc[ne] = c;
      ne++;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(1'b0, 1'b0, 0, 0, 0);
    cyc(1'b1, 1'b1, 5, 5, 5);
    rst = 1'b0;
    clk_no = 0;
  endtask

  initial begin : watchdog
    #(8ns * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int first_out;
    int last_out;
    @(negedge clk);
    do_reset();
    // R1: reset state
    chk("R1 reset valid", longint'(out_valid), 0);

    // R4: seven sets back to back, results after clocks 3..9; R8 throughput
    first_out = 0; last_out = 0;
    for (int i = 1; i <= 9; i++) begin
      cyc(1'b1, i <= 7, i, i + 10, 3 * i);
      if (out_valid) begin
        if (first_out == 0) first_out = clk_no;
        last_out = clk_no;
      end
    end
    chk("R4 first result clock", first_out, 3);
    chk("R4 last result clock", last_out, 9);

    // R7: all-ones operands
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 255, 255, 255);
    chk("R7 top bit", longint'(out_result[SW-1]), 0);
    chk("R7 max sum", longint'(out_result), 255 * 255 + 255);

    // R5: bubbles mixed in
    for (int i = 0; i < 40; i++) cyc(1'b1, (i % 3) != 1, $urandom % 256, $urandom % 256, $urandom % 256);

    // R6: stall with changing inputs, outputs must hold
    cyc(1'b1, 1'b1, 17, 19, 23);
    cyc(1'b1, 1'b1, 29, 31, 37);
    begin
      logic [SW-1:0] held;
      logic          heldv;
      held = out_result; heldv = out_valid;
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 200 + i, 100 + i, 99);
      chk("R6 hold result", longint'(out_result), longint'(held));
      chk("R6 hold valid", longint'(out_valid), longint'(heldv));
    end
    cyc(1'b1, 1'b0, 0, 0, 41);
    cyc(1'b1, 1'b0, 0, 0, 43);

    // R2 R3 R6: random enable and valid
    for (int i = 0; i < 400; i++)
      cyc(($urandom % 4) != 0, ($urandom % 5) != 0, $urandom % 256, $urandom % 256, $urandom % 256);

    // R1: reset with sets in flight
    cyc(1'b1, 1'b1, 9, 9, 9);
    cyc(1'b1, 1'b1, 8, 8, 8);
    do_reset();
    chk("R1 in-flight cleared", longint'(out_valid), 0);
    cyc(1'b1, 1'b0, 0, 0, 0);
    chk("R1 stays clear", longint'(out_valid), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule